// File: doc/BRIEF.md
# Protection Region Descriptor Register Front-End

This block holds the descriptor words of a memory-protection unit and exposes them on a simple 32-bit register port. It keeps a base word and an attribute word for each of a parameterised number of regions. A region-number register selects which region the base and attribute registers reach. A write to the base register can also select a region directly, through a valid bit and a region field carried in the written word. The block also holds a small control register whose bits drive the protection enable, the enable-during-fault-handlers and the privileged-default-map outputs. It raises single-cycle pulses when the operating mode has to be re-evaluated or when the privileged mapping has to be flushed.

The logic that matches addresses and checks permissions lies outside this block. That logic reads the descriptors from a neighbouring unit. The register port decodes a 4-bit word offset. Reads return data combinationally from the stored state. Writes take effect at the clock edge on which `bus_valid` and `bus_write` are high.

Top module: `rdr_front`

## Requirements
- R1: A write to the region-number register (offset 2) is ignored when the 32-bit written value, read as unsigned, is not less than `NUM_REGIONS`. An in-range value becomes the current region, and reading offset 2 returns it zero-extended.
- R2: A base write (offset 3) with bit 4 (valid) set and a region field in bits [3:0] below `NUM_REGIONS` first makes that field the current region, and then stores bits [31:5] as that region's base.
- R3: A base write with bit 4 clear, or with a region field of `NUM_REGIONS` or more, stores bits [31:5] into the region already selected and leaves the region number unchanged.
- R4: A read of the base register returns the stored base in bits [31:5], zero in bit 4, and the current region number in bits [3:0].
- R5: The attribute register (offset 4) reads and writes the full 32-bit attribute word of the current region.
- R6: The offset pairs 5/6, 7/8 and 9/10 behave exactly like the base/attribute pair at offsets 3/4.
- R7: The control register (offset 1) stores only bit 0 (protection enable), bit 1 (enable during fault handlers) and bit 2 (privileged default map). All other bits read as zero. The three outputs follow the stored bits from the cycle after the write.
- R8: `mode_change_o` is high for exactly the cycle after a control write that changes bit 0 or bit 1. A write that changes neither bit leaves it low.
- R9: `priv_flush_o` is high for exactly the cycle after a control write that changes bit 2 from 1 to 0. Setting bit 2 does not raise it.
- R10: The type register (offset 0) is read-only. It reports `NUM_REGIONS` in bits [15:8] with zeros elsewhere, and writes to it change nothing.
- R11: Reset clears every descriptor word, the region number and the control register. Offsets 11 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | 4 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prot_enable_o | output | 1 | Control bit 0 |
| fault_enable_o | output | 1 | Control bit 1 |
| priv_default_o | output | 1 | Control bit 2 |
| mode_change_o | output | 1 | One-cycle pulse when bit 0 or bit 1 changes |
| priv_flush_o | output | 1 | One-cycle pulse when bit 2 falls |

## Verification
A write lands at the rising edge on which it is presented. The value it stores, the control outputs and both pulses are all visible for the whole cycle that follows that edge. Read data has no latency and reflects the address presented in the same cycle. The bench therefore drives inputs on falling edges. It checks pulses and outputs at the falling edge right after the write edge, and checks a pulse's return to zero one cycle later. Each read is sampled shortly after its address is applied. After reset is released, the bench waits three clock edges, which covers the two-stage reset release, before it makes any access.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BASE_LSB  = 5;
  localparam int unsigned VALID_BIT = 4;
  localparam int unsigned RFIELD_W  = 4;
  localparam int unsigned TYPE_LSB  = 8;
  localparam int unsigned BASE_W    = DATA_W - BASE_LSB;

  localparam logic [ADDR_W-1:0] OFF_TYPE  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_RNUM  = 4'd2;
  localparam int unsigned       OFF_PAIR0 = 3;

  typedef struct packed {
    logic priv_def;
    logic fault_en;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/rdr_rst_sync.sv
module rdr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rdr_decode.sv
module rdr_decode
  import rdr_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_type,
  output logic              sel_ctrl,
  output logic              sel_rnum,
  output logic              sel_base,
  output logic              sel_attr
);
  logic [NUM_PAIRS-1:0] hit_base;
  logic [NUM_PAIRS-1:0] hit_attr;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int unsigned BOFF = OFF_PAIR0 + 2 * p;
    assign hit_base[p] = (addr == ADDR_W'(BOFF));
    assign hit_attr[p] = (addr == ADDR_W'(BOFF + 1));
  end

  assign sel_type = (addr == OFF_TYPE);
  assign sel_ctrl = (addr == OFF_CTRL);
  assign sel_rnum = (addr == OFF_RNUM);
  assign sel_base = |hit_base;
  assign sel_attr = |hit_attr;
endmodule

// File: rtl/rdr_table.sv
module rdr_table
  import rdr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned IDX_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_attr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BASE_W-1:0] base_wval,
  input  logic [DATA_W-1:0] attr_wval,
  output logic [BASE_W-1:0] base_rd,
  output logic [DATA_W-1:0] attr_rd
);
  logic [BASE_W-1:0] base_q [NUM_REGIONS];
  logic [DATA_W-1:0] attr_q [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic hit;
    assign hit = (idx == IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[r] <= '0;
        attr_q[r] <= '0;
      end else begin
        if (wr_base && hit) base_q[r] <= base_wval;
        if (wr_attr && hit) attr_q[r] <= attr_wval;
      end
    end
  end

  assign base_rd = base_q[idx];
  assign attr_rd = attr_q[idx];

  // R5
  attr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_attr && !wr_base) |=> (attr_q[$past(idx)] == $past(attr_wval)));
endmodule

// File: rtl/rdr_ctrl.sv
module rdr_ctrl
  import rdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  output ctrl_t ctrl_o,
  output logic  mode_o,
  output logic  flush_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  mode_q, mode_d;
  logic  flush_q, flush_d;

  always_comb begin
    ctrl_d  = wr_en ? wr_val : ctrl_q;
    mode_d  = (ctrl_d.enable != ctrl_q.enable) || (ctrl_d.fault_en != ctrl_q.fault_en);
    flush_d = ctrl_q.priv_def && !ctrl_d.priv_def;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mode_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mode_q  <= mode_d;
      flush_q <= flush_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign mode_o  = mode_q;
  assign flush_o = flush_q;

  // R9
  flush_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.priv_def) |-> flush_q);

  // R9
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $fell(ctrl_q.priv_def));

  // R8
  mode_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (ctrl_q.enable != $past(ctrl_q.enable) ||
                ctrl_q.fault_en != $past(ctrl_q.fault_en)));
endmodule

// File: rtl/rdr_front.sv
module rdr_front
  import rdr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_PAIRS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        prot_enable_o,
  output logic        fault_enable_o,
  output logic        priv_default_o,
  output logic        mode_change_o,
  output logic        priv_flush_o
);
  localparam int unsigned RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic rst_i_n;
  logic sel_type, sel_ctrl, sel_rnum, sel_base, sel_attr;
  logic wr;
  logic rnum_ok, retarget;
  logic [RIDX_W-1:0] rnum_q, rnum_d, tbl_idx;
  logic [BASE_W-1:0] base_rd;
  logic [DATA_W-1:0] attr_rd;
  logic [DATA_W-1:0] rnum_ext;
  logic [DATA_W-1:0] field_ext;
  ctrl_t ctrl;

  rdr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  rdr_decode #(.NUM_PAIRS(NUM_PAIRS)) u_dec (
    .addr(bus_addr), .sel_type(sel_type), .sel_ctrl(sel_ctrl),
    .sel_rnum(sel_rnum), .sel_base(sel_base), .sel_attr(sel_attr)
  );

  assign wr        = bus_valid && bus_write;
  assign field_ext = DATA_W'(bus_wdata[RFIELD_W-1:0]);
  assign rnum_ok   = wr && sel_rnum && (bus_wdata < DATA_W'(NUM_REGIONS));
  assign retarget  = wr && sel_base && bus_wdata[VALID_BIT] &&
                     (field_ext < DATA_W'(NUM_REGIONS));

  always_comb begin
    rnum_d = rnum_q;
    if (rnum_ok || retarget) rnum_d = bus_wdata[RIDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rnum_q <= '0;
    else          rnum_q <= rnum_d;
  end

  assign tbl_idx = retarget ? bus_wdata[RIDX_W-1:0] : rnum_q;

  rdr_table #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(RIDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_i_n),
    .wr_base(wr && sel_base), .wr_attr(wr && sel_attr),
    .idx(tbl_idx),
    .base_wval(bus_wdata[DATA_W-1:BASE_LSB]), .attr_wval(bus_wdata),
    .base_rd(base_rd), .attr_rd(attr_rd)
  );

  rdr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr && sel_ctrl), .wr_val(ctrl_t'(bus_wdata[2:0])),
    .ctrl_o(ctrl), .mode_o(mode_change_o), .flush_o(priv_flush_o)
  );

  assign rnum_ext = DATA_W'(rnum_q);

  always_comb begin
    bus_rdata = '0;
    if (sel_type)      bus_rdata = DATA_W'(NUM_REGIONS) << TYPE_LSB;
    else if (sel_ctrl) bus_rdata = DATA_W'(ctrl);
    else if (sel_rnum) bus_rdata = rnum_ext;
    else if (sel_base) bus_rdata = {base_rd, 1'b0, rnum_ext[RFIELD_W-1:0]};
    else if (sel_attr) bus_rdata = attr_rd;
  end

  assign prot_enable_o  = ctrl.enable;
  assign fault_enable_o = ctrl.fault_en;
  assign priv_default_o = ctrl.priv_def;

  // R1
  rnum_reject_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr && sel_rnum && bus_wdata >= DATA_W'(NUM_REGIONS)) |=> $stable(rnum_q));

  // R2
  retarget_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr && sel_base && bus_wdata[VALID_BIT] && bus_wdata[RFIELD_W-1:0] < NUM_REGIONS)
      |=> (rnum_q == $past(bus_wdata[RIDX_W-1:0])));

  // R3
  keep_region_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr && sel_base && !bus_wdata[VALID_BIT]) |=> $stable(rnum_q));

  // R11
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({sel_type, sel_ctrl, sel_rnum, sel_base, sel_attr}));
endmodule

// File: tb/rdr_front_test.sv
module rdr_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic prot_enable_o, fault_enable_o, priv_default_o, mode_change_o, priv_flush_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rdr_front uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prot_enable_o(prot_enable_o), .fault_enable_o(fault_enable_o),
    .priv_default_o(priv_default_o), .mode_change_o(mode_change_o),
    .priv_flush_o(priv_flush_o)
  );

  // {req tag number, write, offset, data, expected read}
  localparam int NV = 37;
  localparam logic [72:0] VEC [NV] = '{
    {4'd10, 1'b0, 4'd0,  32'h0,         32'h0000_0800}, // R10 type value
    {4'd11, 1'b0, 4'd2,  32'h0,         32'h0},         // R11 reset number
    {4'd11, 1'b0, 4'd3,  32'h0,         32'h0},         // R11 reset base
    {4'd1,  1'b1, 4'd2,  32'h3,         32'h0},
    {4'd1,  1'b0, 4'd2,  32'h0,         32'h3},         // R1 accepted
    {4'd1,  1'b1, 4'd2,  32'h8,         32'h0},
    {4'd1,  1'b0, 4'd2,  32'h0,         32'h3},         // R1 value 8 ignored
    {4'd1,  1'b1, 4'd2,  32'hFFFF_FFFF, 32'h0},
    {4'd1,  1'b0, 4'd2,  32'h0,         32'h3},         // R1 huge ignored
    {4'd3,  1'b1, 4'd3,  32'h1000_0000, 32'h0},
    {4'd3,  1'b0, 4'd3,  32'h0,         32'h1000_0003}, // R3 R4
    {4'd5,  1'b1, 4'd4,  32'hABCD_0001, 32'h0},
    {4'd5,  1'b0, 4'd4,  32'h0,         32'hABCD_0001}, // R5
    {4'd2,  1'b1, 4'd3,  32'h2000_0015, 32'h0},
    {4'd2,  1'b0, 4'd2,  32'h0,         32'h5},         // R2 number updated
    {4'd2,  1'b0, 4'd3,  32'h0,         32'h2000_0005}, // R2 base stored
    {4'd3,  1'b1, 4'd3,  32'h3000_001C, 32'h0},
    {4'd3,  1'b0, 4'd2,  32'h0,         32'h5},         // R3 out-of-range field
    {4'd3,  1'b0, 4'd3,  32'h0,         32'h3000_0005}, // R3
    {4'd5,  1'b1, 4'd2,  32'h3,         32'h0},
    {4'd5,  1'b0, 4'd4,  32'h0,         32'hABCD_0001}, // R5 region 3 kept
    {4'd3,  1'b0, 4'd3,  32'h0,         32'h1000_0003}, // R3 region 3 untouched
    {4'd6,  1'b1, 4'd7,  32'h4000_0012, 32'h0},
    {4'd6,  1'b1, 4'd8,  32'h5555_0000, 32'h0},
    {4'd6,  1'b0, 4'd2,  32'h0,         32'h2},         // R6 alias retarget
    {4'd6,  1'b0, 4'd4,  32'h0,         32'h5555_0000}, // R6
    {4'd6,  1'b0, 4'd5,  32'h0,         32'h4000_0002}, // R6
    {4'd6,  1'b0, 4'd9,  32'h0,         32'h4000_0002}, // R6
    {4'd4,  1'b1, 4'd3,  32'hFFFF_FFF0, 32'h0},
    {4'd4,  1'b0, 4'd3,  32'h0,         32'hFFFF_FFE0}, // R4 valid bit reads 0
    {4'd7,  1'b1, 4'd1,  32'hFFFF_FFFF, 32'h0},
    {4'd7,  1'b0, 4'd1,  32'h0,         32'h7},         // R7 writable bits
    {4'd10, 1'b1, 4'd0,  32'hFFFF_FFFF, 32'h0},
    {4'd10, 1'b0, 4'd0,  32'h0,         32'h0000_0800}, // R10 read-only
    {4'd11, 1'b1, 4'd14, 32'hFFFF_FFFF, 32'h0},
    {4'd11, 1'b0, 4'd14, 32'h0,         32'h0},         // R11 unmapped
    {4'd11, 1'b0, 4'd2,  32'h0,         32'h0}          // R11 unmapped write no effect
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic apply_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] rd;
    apply_reset();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) do_write(VEC[i][67:64], VEC[i][63:32]);
      else begin
        do_read(VEC[i][67:64], rd);
        check($sformatf("R%0d vector %0d", VEC[i][72:69], i), rd, VEC[i][31:0]);
      end
    end
    // R7 outputs follow stored bits
    check("R7 outputs", {29'b0, priv_default_o, fault_enable_o, prot_enable_o}, 32'h7);

    // R11 reset clears everything
    apply_reset();
    check("R11 outputs after reset",
          {27'b0, priv_flush_o, mode_change_o, priv_default_o, fault_enable_o, prot_enable_o}, 32'h0);
    do_read(4'd1, rd); check("R11 ctrl after reset", rd, 32'h0);
    do_read(4'd2, rd); check("R11 number after reset", rd, 32'h0);
    do_write(4'd2, 32'h5);
    do_read(4'd4, rd); check("R11 attr after reset", rd, 32'h0);
    do_write(4'd2, 32'h0);

    // R8 enable set raises mode pulse for one cycle
    do_write(4'd1, 32'h1);
    check("R8 mode pulse on enable", {31'b0, mode_change_o}, 32'h1);
    check("R9 no flush on enable", {31'b0, priv_flush_o}, 32'h0);
    check("R7 enable output", {31'b0, prot_enable_o}, 32'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, mode_change_o}, 32'h0);

    // R8 setting only the privileged bit: no mode pulse; R9 no flush on set
    do_write(4'd1, 32'h5);
    check("R8 no pulse on priv set", {31'b0, mode_change_o}, 32'h0);
    check("R9 no flush on priv set", {31'b0, priv_flush_o}, 32'h0);
    check("R7 priv default output", {31'b0, priv_default_o}, 32'h1);

    // R9 clearing privileged bit flushes
    do_write(4'd1, 32'h1);
    check("R9 flush on priv clear", {31'b0, priv_flush_o}, 32'h1);
    check("R8 no pulse on priv clear", {31'b0, mode_change_o}, 32'h0);
    @(negedge clk);
    check("R9 flush one cycle", {31'b0, priv_flush_o}, 32'h0);

    // R8 fault-handler bit change
    do_write(4'd1, 32'h3);
    check("R8 pulse on fault enable", {31'b0, mode_change_o}, 32'h1);
    do_write(4'd1, 32'h3);
    check("R8 no pulse on same value", {31'b0, mode_change_o}, 32'h0);

    done = 1'b1;
    finish_up();
  end
endmodule